// File: doc/BRIEF.md
# Triplicated Pixel Configuration Chain

This block holds the per-pixel settings of a group of pixel columns and loads them over a single serial chain driven by a master at the end of the column. Each pixel carries a configuration word made of a threshold trim code plus mask, test-inject and spare control bits. One chain threads through the pixels of four columns. The master shifts a complete image in, then pulses a load strobe that copies the whole shift chain into the active registers that feed the pixels. Because the shift chain is also presented at a serial output, the master can read back what it wrote.

Every stored bit, in the shift stages and in the active registers alike, is held in three copies. The value that is used is the 2-of-3 majority. On every clock each copy is rewritten with the voted value, so a single upset copy is repaired on the next edge without any command. Any disagreement among the copies raises a sticky upset flag that only a dedicated clear input lowers.

Top module: `pixcfg_tmr_chain`

## Requirements
- R1: Asserting rst_n low clears every copy at once: sdo, trim_o, mask_o, inject_o, spare_o and upset_o all read 0 (trim zero, pixel unmasked).
- R2: In a cycle with shift_en high, sdi enters chain stage 0 and every stage k takes the voted value of stage k-1; sdo always shows the voted value of the last stage (index 4*PIX_PER_COL*(TRIM_W+3)-1), so the first bit shifted in reaches sdo after one full chain length of shifts.
- R3: With shift_en low the chain holds, whatever sdi does.
- R4: A cycle with load high copies all shift stages into the active registers; the outputs show them from the next cycle. Pixel p owns chain bits [p*(TRIM_W+3) +: TRIM_W+3]: bits 0..TRIM_W-1 are trim (LSB first), then mask, then test-inject, then spare.
- R5: With load low the active outputs keep their value, including while the chain shifts.
- R6: When load and shift_en are high in the same cycle, the active registers take the chain contents from before that shift.
- R7: An upset of one copy of any bit does not change any output.
- R8: A single upset copy is rewritten with the voted value at the next clock edge, so a later upset of a different copy of the same bit still leaves the outputs unchanged.
- R9: upset_o goes high in the cycle after any copy mismatch is seen, in either the chain or the active registers, and stays high while flag_clr is low.
- R10: flag_clr high lowers upset_o at the next edge; if a mismatch is seen in the same cycle, upset_o stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sdi | input | 1 | Serial configuration data from the master |
| shift_en | input | 1 | Advance the chain by one stage |
| load | input | 1 | Copy the chain into the active registers |
| flag_clr | input | 1 | Clear the sticky upset flag |
| sdo | output | 1 | Voted last chain stage, for readback |
| trim_o | output | 4*PIX_PER_COL*TRIM_W | Trim codes, pixel p at [p*TRIM_W +: TRIM_W] |
| mask_o | output | 4*PIX_PER_COL | Mask bit per pixel |
| inject_o | output | 4*PIX_PER_COL | Test-inject enable per pixel |
| spare_o | output | 4*PIX_PER_COL | Spare control bit per pixel |
| upset_o | output | 1 | Sticky flag: a copy mismatch was corrected |

## Verification
The hard case is a single-copy upset, which no port can cause and which a correct design hides at every output. The stimulus deposits a flipped bit into one copy register of the chain or of the active bank between clock edges, then, one cycle later, flips a different copy of the same bit; only a design that repaired the first upset keeps its outputs stable, and the flag timing around flag_clr is compared against the model cycle by cycle, including a clear that coincides with an upset.

// File: rtl/pixcfg_pkg.sv
package pixcfg_pkg;
  localparam int TRIM_BITS  = 5;
  localparam int CTRL_BITS  = 3;
  localparam int CHAIN_COLS = 4;
  // control bit offsets above the trim field
  localparam int MASK_OFS   = 0;
  localparam int INJ_OFS    = 1;
  localparam int SPARE_OFS  = 2;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stg1_q;
  logic stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign rst_sync_n = stg2_q;
endmodule

// File: rtl/tmr_word.sv
module tmr_word #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         mismatch
);
  logic [W-1:0] c0;
  logic [W-1:0] c1;
  logic [W-1:0] c2;
  logic [W-1:0] voted;
  logic [W-1:0] nxt;

  always_comb begin
    voted    = (c0 & c1) | (c0 & c2) | (c1 & c2);
    mismatch = |((c0 ^ c1) | (c0 ^ c2));
    // writing the voted value back every cycle repairs a lone upset copy
    nxt      = we ? d : voted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0 <= '0;
      c1 <= '0;
      c2 <= '0;
    end else begin
      c0 <= nxt;
      c1 <= nxt;
      c2 <= nxt;
    end
  end

  assign q = voted;
endmodule

// File: rtl/pixcfg_tmr_chain.sv
module pixcfg_tmr_chain
  import pixcfg_pkg::*;
#(
  parameter int PIX_PER_COL = 40,
  parameter int COLS        = CHAIN_COLS,
  parameter int TRIM_W      = TRIM_BITS
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sdi,
  input  logic                              shift_en,
  input  logic                              load,
  input  logic                              flag_clr,
  output logic                              sdo,
  output logic [COLS*PIX_PER_COL*TRIM_W-1:0] trim_o,
  output logic [COLS*PIX_PER_COL-1:0]       mask_o,
  output logic [COLS*PIX_PER_COL-1:0]       inject_o,
  output logic [COLS*PIX_PER_COL-1:0]       spare_o,
  output logic                              upset_o
);
  localparam int PIX_W = TRIM_W + CTRL_BITS;
  localparam int NPIX  = COLS * PIX_PER_COL;
  localparam int LEN   = NPIX * PIX_W;

  logic           rst_ok;
  logic [LEN-1:0] shift_q;
  logic [LEN-1:0] shift_d;
  logic [LEN-1:0] act_q;
  logic           mm_shift;
  logic           mm_act;
  logic           any_mm;
  logic           flag_q;
  logic           flag_d;

  cfg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ok)
  );

  assign shift_d = {shift_q[LEN-2:0], sdi};

  tmr_word #(.W(LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_ok),
    .we       (shift_en),
    .d        (shift_d),
    .q        (shift_q),
    .mismatch (mm_shift)
  );

  // active bank captures the chain as it stands before any same-cycle shift
  tmr_word #(.W(LEN)) u_act (
    .clk      (clk),
    .rst_n    (rst_ok),
    .we       (load),
    .d        (shift_q),
    .q        (act_q),
    .mismatch (mm_act)
  );

  always_comb begin
    any_mm = mm_shift | mm_act;
    flag_d = (flag_q & ~flag_clr) | any_mm;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  genvar p;
  generate
    for (p = 0; p < NPIX; p++) begin : g_pix
      assign trim_o[p*TRIM_W +: TRIM_W] = act_q[p*PIX_W +: TRIM_W];
      assign mask_o[p]   = act_q[p*PIX_W + TRIM_W + MASK_OFS];
      assign inject_o[p] = act_q[p*PIX_W + TRIM_W + INJ_OFS];
      assign spare_o[p]  = act_q[p*PIX_W + TRIM_W + SPARE_OFS];
    end
  endgenerate

  assign sdo     = shift_q[LEN-1];
  assign upset_o = flag_q;
endmodule

// File: rtl/pixcfg_tmr_chain_chk.sv
module pixcfg_tmr_chain_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         shift_en,
  input logic         load,
  input logic         flag_clr,
  input logic         sdo,
  input logic         prev_bit,
  input logic [W-1:0] act_q,
  input logic         any_mm,
  input logic         upset_o
);
  AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_ok)
    shift_en |=> (sdo == $past(prev_bit))); // R2

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !shift_en |=> $stable(sdo)); // R3

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !load |=> $stable(act_q)); // R5

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    any_mm |=> upset_o); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_ok)
    (upset_o && !flag_clr) |=> upset_o); // R9

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_ok)
    (flag_clr && !any_mm) |=> !upset_o); // R10
endmodule

bind pixcfg_tmr_chain pixcfg_tmr_chain_chk #(.W(LEN)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_ok),
  .shift_en (shift_en),
  .load     (load),
  .flag_clr (flag_clr),
  .sdo      (sdo),
  .prev_bit (shift_q[LEN-2]),
  .act_q    (act_q),
  .any_mm   (any_mm),
  .upset_o  (upset_o)
);

// File: tb/test_pixcfg_tmr_chain.sv
module test_pixcfg_tmr_chain;
  localparam int CLK_PERIOD = 10;
  localparam int PPC   = 40;
  localparam int COLS  = 4;
  localparam int TW    = 5;
  localparam int PW    = TW + 3;
  localparam int NPIX  = COLS * PPC;
  localparam int LEN   = NPIX * PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdi = 1'b0, shift_en = 1'b0, load = 1'b0, flag_clr = 1'b0;
  logic sdo, upset_o;
  logic [NPIX*TW-1:0] trim_o;
  logic [NPIX-1:0] mask_o, inject_o, spare_o;

  pixcfg_tmr_chain #(.PIX_PER_COL(PPC), .COLS(COLS), .TRIM_W(TW)) i_pixcfg_tmr_chain (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .shift_en(shift_en), .load(load),
    .flag_clr(flag_clr), .sdo(sdo), .trim_o(trim_o), .mask_o(mask_o),
    .inject_o(inject_o), .spare_o(spare_o), .upset_o(upset_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit running = 0;
  string phase = "R1 reset";

  // behavioural reference
  logic [LEN-1:0] m_shift = '0;
  logic [LEN-1:0] m_act   = '0;
  logic           m_flag  = 1'b0;
  bit             upset_pend = 0;
  logic [LEN-1:0] inj_val;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_shift = '0; m_act = '0; m_flag = 1'b0; upset_pend = 0;
    end else begin
      if (load) m_act = m_shift;
      if (shift_en) m_shift = {m_shift[LEN-2:0], sdi};
      m_flag = (m_flag && !flag_clr) || upset_pend;
      upset_pend = 0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      bit ok_out = 1;
      chk({phase, " sdo (R2)"}, 64'(sdo), 64'(m_shift[LEN-1]));
      chk({phase, " upset_o (R9)"}, 64'(upset_o), 64'(m_flag));
      for (int p = 0; p < NPIX; p++) begin
        if (trim_o[p*TW +: TW] !== m_act[p*PW +: TW] || mask_o[p] !== m_act[p*PW+TW] ||
            inject_o[p] !== m_act[p*PW+TW+1] || spare_o[p] !== m_act[p*PW+TW+2]) ok_out = 0;
      end
      chk({phase, " pixel outputs (R4)"}, 64'(ok_out), 64'd1);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    shift_en = 0; load = 0; flag_clr = 0;
    repeat (n) step();
  endtask

  function automatic logic pat(input int i, input int sel);
    return sel == 0 ? logic'(((i * 7) % 5 == 0) ^ (i % 3 == 1)) : logic'(((i * 13) % 11) < 5);
  endfunction

  task automatic shift_in(input int sel, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = pat(i, sel); shift_en = 1; load = 0; flag_clr = 0;
      step();
    end
    shift_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; shift_en = 0; load = 0; flag_clr = 0;
    step(); step();
    chk("R1 reset sdo", 64'(sdo), 64'd0);
    chk("R1 reset trim", 64'(|trim_o), 64'd0);
    chk("R1 reset mask/inject/spare", 64'(|{mask_o, inject_o, spare_o}), 64'd0);
    chk("R1 reset upset", 64'(upset_o), 64'd0);
    rst_n = 1;
    idle(4);
  endtask

  // flip bit k in one copy (0..2) of the chain (bank 0) or active bank (1)
  task automatic inject(input int bank, input int cp, input int k);
    inj_val = (bank == 0 ? m_shift : m_act) ^ (LEN'(1) << k);
    if (bank == 0) begin
      case (cp)
        0: force i_pixcfg_tmr_chain.u_chain.c0 = inj_val;
        1: force i_pixcfg_tmr_chain.u_chain.c1 = inj_val;
        default: force i_pixcfg_tmr_chain.u_chain.c2 = inj_val;
      endcase
      #1;
      case (cp)
        0: release i_pixcfg_tmr_chain.u_chain.c0;
        1: release i_pixcfg_tmr_chain.u_chain.c1;
        default: release i_pixcfg_tmr_chain.u_chain.c2;
      endcase
    end else begin
      case (cp)
        0: force i_pixcfg_tmr_chain.u_act.c0 = inj_val;
        1: force i_pixcfg_tmr_chain.u_act.c1 = inj_val;
        default: force i_pixcfg_tmr_chain.u_act.c2 = inj_val;
      endcase
      #1;
      case (cp)
        0: release i_pixcfg_tmr_chain.u_act.c0;
        1: release i_pixcfg_tmr_chain.u_act.c1;
        default: release i_pixcfg_tmr_chain.u_act.c2;
      endcase
    end
    upset_pend = 1;
  endtask

  initial begin
    running = 1;
    do_reset();

    phase = "R2 shift A";
    shift_in(0, LEN);
    phase = "R3 hold";
    for (int i = 0; i < 8; i++) begin sdi = ~sdi; step(); end
    phase = "R4 load";
    load = 1; step(); load = 0;
    idle(2);
    phase = "R5 shift B under held outputs";
    shift_in(1, LEN / 2 + 3);
    phase = "R6 load with shift";
    sdi = 1; shift_en = 1; load = 1; step();
    shift_en = 0; load = 0;
    idle(2);
    phase = "R2 readback";
    shift_in(0, LEN);
    load = 1; step(); load = 0;
    idle(2);

    phase = "R7 chain upset";
    inject(0, 1, LEN - 1); step();
    phase = "R8 chain repair";
    inject(0, 2, LEN - 1); step();
    idle(2);
    phase = "R10 clear";
    flag_clr = 1; step(); flag_clr = 0;
    idle(2);
    phase = "R7 active upset";
    for (int k = 0; k < PW; k++) begin
      inject(1, 0, 9 * PW + k); step();
      phase = "R8 active repair";
      inject(1, 1, 9 * PW + k); step();
    end
    phase = "R10 clear with upset";
    flag_clr = 1; inject(1, 2, 3); step(); flag_clr = 0;
    idle(2);
    phase = "R9 sticky";
    idle(3);
    flag_clr = 1; step(); flag_clr = 0;
    idle(2);

    phase = "R1 mid-run reset";
    do_reset();
    idle(2);

    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule